// File: doc/BRIEF.md
# Condition-Code Flag Unit with Interrupt Gating

This block keeps the 8-bit condition-code register of a processor core. It derives the arithmetic flags for byte, word and long operations from the operation code, the operand size, the two operands and the result that the ALU has already computed. It also applies control-register operations issued by software: load, AND, OR, XOR and store. A core uses it next to its ALU. The instruction decoder drives the operation and control inputs, and the exception sequencer reads the interrupt-accept outputs.

Interrupt gating has two parts. The mask bit (bit 7) blocks the maskable request but never the non-maskable one. A short state machine blocks both requests for three clock cycles after any control operation that changes the register, and a store does not start it. The state machine has four states. Open (HS_OPEN) is the state after reset and accepts requests. Hold1, Hold2 and Hold3 (HS_HOLD1, HS_HOLD2, HS_HOLD3) block every request. Its transitions are:
- arm: from any state, a load, AND, OR or XOR moves it to Hold1.
- step: otherwise, Hold1 moves to Hold2 and Hold2 moves to Hold3.
- release: otherwise, Hold3 moves to Open.
- idle: otherwise, Open stays in Open.

Top module: `ccr_flag_unit`

## Requirements
- R1: A synchronous active-high reset sets the register to 8'h80 (mask set, all else clear) and puts the hold-off machine in Open, so a non-maskable request is accepted in the first cycle after reset.
- R2: The bit layout, from bit 7 down to bit 0, is mask I, user/mask UI, half-carry H, user U, N, Z, V, C. For add, add-with-extend, subtract, subtract-with-extend, compare and negate, H is loaded with the carry or borrow out of bit 3 for byte size, bit 11 for word size and bit 27 for long size. The size code is 2'b00 byte, 2'b01 word, 2'b10 long.
- R3: N takes bit 7, 15 or 31 of the result for the active size. Z is 1 exactly when the result bits of the active size are all zero. Operand and result bits above the active size have no effect.
- R4: For add-type operations, V is set when both operands have the same sign and the result's sign differs from it. For subtract-type operations (negate being 0 minus the operand), V is set when the operands' signs differ and the result's sign differs from the minuend's. V is cleared otherwise.
- R5: C holds the carry out of the top bit of the active size for add-type operations, and the borrow for subtract-type operations. The extended forms take the old C as carry-in or borrow-in. Operation codes: 0 add, 1 add-with-extend, 2 subtract, 3 subtract-with-extend, 4 compare, 5 negate, 6 shift/rotate left, 7 shift/rotate right.
- R6: For codes 6 and 7, C takes the bit that leaves the operand (its top bit for left, bit 0 for right), V is cleared, and H keeps its value.
- R7: Control codes are 0 none, 1 load, 2 AND, 3 OR, 4 XOR, 5 store. Load, AND, OR and XOR combine ctl_data with all eight bits, UI and U included. A store leaves the register unchanged. A control operation takes priority over an ALU flag update in the same cycle.
- R8: exc_start forces I to 1 in the next register value, after any same-cycle control operation has been applied, and leaves the other bits unchanged.
- R9: irq_ack is high only while irq_req is high, I is 0 and no hold-off is active. nmi_ack follows nmi_req whenever no hold-off is active, whatever the value of I.
- R10: After a load, AND, OR or XOR is captured, both acknowledges are held low for the next three cycles, and a further such operation restarts the count. A store starts no hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | ALU flag update this cycle |
| alu_op | input | 3 | Operation code (R5 encoding) |
| alu_size | input | 2 | Operand size: 00 byte, 01 word, 10 long |
| opnd_a | input | 32 | First operand (minuend, or negate/shift source) |
| opnd_b | input | 32 | Second operand (addend or subtrahend) |
| alu_result | input | 32 | Result computed by the ALU |
| ctl_op | input | 3 | Control-register operation (R7 encoding) |
| ctl_data | input | 8 | Immediate or source value for the control operation |
| exc_start | input | 1 | Start of an exception-handling sequence |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ccr_q | output | 8 | Current condition-code register (read by store) |
| irq_ack | output | 1 | Maskable interrupt accepted |
| nmi_ack | output | 1 | Non-maskable interrupt accepted |

## Verification
The situation that is hardest to reach is a carry or overflow at exactly the size boundary while junk sits in the bits above it. For byte and word sizes, the stimulus fills the bits above the active size of the operands and of the result with a fixed non-zero pattern. It then sweeps a set of byte values chosen to sit on the carry and sign edges, repeated across the active width, over every operation code and size. The extended forms run in a chain, so they pick up both values of the old carry. The three-cycle hold-off is sampled in each of the three blocked cycles and in the first open cycle, for every control operation, with both requests held high.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDX = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBX = 3'd3,
        OP_CMP  = 3'd4,
        OP_NEG  = 3'd5,
        OP_SHL  = 3'd6,
        OP_SHR  = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        CTL_NONE  = 3'd0,
        CTL_LOAD  = 3'd1,
        CTL_AND   = 3'd2,
        CTL_OR    = 3'd3,
        CTL_XOR   = 3'd4,
        CTL_STORE = 3'd5
    } ctl_op_e;

    typedef enum logic [1:0] {
        HS_OPEN  = 2'd0,
        HS_HOLD1 = 2'd1,
        HS_HOLD2 = 2'd2,
        HS_HOLD3 = 2'd3
    } hold_state_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam int POS_I  = 7;
    localparam int POS_UI = 6;
    localparam int POS_H  = 5;
    localparam int POS_U  = 4;
    localparam int POS_N  = 3;
    localparam int POS_Z  = 2;
    localparam int POS_V  = 1;
    localparam int POS_C  = 0;

endpackage

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
    import ccr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HC_OFS = 4
) (
    input  logic [2:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] res,
    input  logic              h_old,
    output flags_t            flags
);
    localparam int IDX_W    = $clog2(DATA_W);
    localparam int BYTE_MSB = 7;
    localparam int WORD_MSB = 15;
    localparam int LONG_MSB = DATA_W - 1;

    logic [IDX_W-1:0]  msb;
    logic [IDX_W-1:0]  hc_idx;
    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] minu;
    logic [DATA_W-1:0] subt;
    logic [DATA_W-1:0] carry_vec;
    logic              sa, sb, sr;
    alu_op_e           op_e;

    assign op_e = alu_op_e'(op);

    always_comb begin
        unique case (size)
            2'b00: begin
                msb       = IDX_W'(BYTE_MSB);
                size_mask = DATA_W'({(BYTE_MSB+1){1'b1}});
            end
            2'b01: begin
                msb       = IDX_W'(WORD_MSB);
                size_mask = DATA_W'({(WORD_MSB+1){1'b1}});
            end
            default: begin
                msb       = IDX_W'(LONG_MSB);
                size_mask = {DATA_W{1'b1}};
            end
        endcase
    end

    // carry into the bit above the half-carry position
    assign hc_idx    = msb - IDX_W'(HC_OFS - 1);
    assign minu      = (op_e == OP_NEG) ? '0 : a;
    assign subt      = (op_e == OP_NEG) ? a  : b;
    assign carry_vec = minu ^ subt ^ res;
    assign sa        = minu[msb];
    assign sb        = subt[msb];
    assign sr        = res[msb];

    always_comb begin
        flags.n = sr;
        flags.z = ((res & size_mask) == '0);
        flags.h = carry_vec[hc_idx];
        unique case (op_e)
            OP_ADD, OP_ADDX: begin
                flags.c = (sa & sb) | ((sa | sb) & ~sr);
                flags.v = (sa == sb) && (sr != sa);
            end
            OP_SUB, OP_SUBX, OP_CMP, OP_NEG: begin
                flags.c = (~sa & sb) | ((~sa | sb) & sr);
                flags.v = (sa != sb) && (sr != sa);
            end
            OP_SHL: begin
                flags.c = a[msb];
                flags.v = 1'b0;
                flags.h = h_old;
            end
            OP_SHR: begin
                flags.c = a[0];
                flags.v = 1'b0;
                flags.h = h_old;
            end
        endcase
    end

endmodule

// File: rtl/ccr_holdoff_fsm.sv
module ccr_holdoff_fsm
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic blocked
);
    hold_state_e state_q;
    hold_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= HS_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        if (arm) begin
            state_d = HS_HOLD1;
        end else begin
            unique case (state_q)
                HS_OPEN:  state_d = HS_OPEN;
                HS_HOLD1: state_d = HS_HOLD2;
                HS_HOLD2: state_d = HS_HOLD3;
                HS_HOLD3: state_d = HS_OPEN;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            HS_OPEN:  blocked = 1'b0;
            HS_HOLD1: blocked = 1'b1;
            HS_HOLD2: blocked = 1'b1;
            HS_HOLD3: blocked = 1'b1;
        endcase
    end

endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate (
    input  logic irq_req,
    input  logic nmi_req,
    input  logic mask_i,
    input  logic blocked,
    output logic irq_ack,
    output logic nmi_ack
);
    assign irq_ack = irq_req & ~mask_i & ~blocked;
    assign nmi_ack = nmi_req & ~blocked;
endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
    import ccr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CCR_W  = 8,
    parameter int HC_OFS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_valid,
    input  logic [2:0]        alu_op,
    input  logic [1:0]        alu_size,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_result,
    input  logic [2:0]        ctl_op,
    input  logic [CCR_W-1:0]  ctl_data,
    input  logic              exc_start,
    input  logic              irq_req,
    input  logic              nmi_req,
    output logic [CCR_W-1:0]  ccr_q,
    output logic              irq_ack,
    output logic              nmi_ack
);
    localparam logic [CCR_W-1:0] RESET_VAL = CCR_W'(1) << POS_I;

    logic [CCR_W-1:0] ccr_r;
    logic [CCR_W-1:0] ccr_d;
    flags_t           alu_flags;
    logic             arm;
    logic             blocked;
    ctl_op_e          ctl_e;

    assign ctl_e = ctl_op_e'(ctl_op);

    ccr_flag_calc #(.DATA_W(DATA_W), .HC_OFS(HC_OFS)) calc_i (
        .op    (alu_op),
        .size  (alu_size),
        .a     (opnd_a),
        .b     (opnd_b),
        .res   (alu_result),
        .h_old (ccr_r[POS_H]),
        .flags (alu_flags)
    );

    always_comb begin
        ccr_d = ccr_r;
        arm   = 1'b0;
        if (alu_valid) begin
            ccr_d[POS_H] = alu_flags.h;
            ccr_d[POS_N] = alu_flags.n;
            ccr_d[POS_Z] = alu_flags.z;
            ccr_d[POS_V] = alu_flags.v;
            ccr_d[POS_C] = alu_flags.c;
        end
        case (ctl_e)
            CTL_LOAD: begin ccr_d = ctl_data;          arm = 1'b1; end
            CTL_AND:  begin ccr_d = ccr_r & ctl_data;  arm = 1'b1; end
            CTL_OR:   begin ccr_d = ccr_r | ctl_data;  arm = 1'b1; end
            CTL_XOR:  begin ccr_d = ccr_r ^ ctl_data;  arm = 1'b1; end
            default:  ;
        endcase
        if (exc_start) ccr_d[POS_I] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ccr_r <= RESET_VAL;
        else     ccr_r <= ccr_d;
    end

    ccr_holdoff_fsm hold_i (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .blocked (blocked)
    );

    ccr_irq_gate gate_i (
        .irq_req (irq_req),
        .nmi_req (nmi_req),
        .mask_i  (ccr_r[POS_I]),
        .blocked (blocked),
        .irq_ack (irq_ack),
        .nmi_ack (nmi_ack)
    );

    assign ccr_q = ccr_r;

endmodule

// File: rtl/ccr_flag_unit_chk.sv
module ccr_flag_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_valid,
    input logic [2:0] alu_op,
    input logic [2:0] ctl_op,
    input logic [7:0] ctl_data,
    input logic       exc_start,
    input logic       irq_req,
    input logic       nmi_req,
    input logic [7:0] ccr_q,
    input logic       irq_ack,
    input logic       nmi_ack
);
    logic arm_c;
    logic arm_live;
    assign arm_c    = (ctl_op == 3'd1) || (ctl_op == 3'd2) || (ctl_op == 3'd3) || (ctl_op == 3'd4);
    assign arm_live = arm_c && !rst;

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (ccr_q == 8'h80));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (!ccr_q[7] && irq_req));

    assert_nmi_free_R9: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !$past(arm_c, 1) && !$past(arm_c, 2) && !$past(arm_c, 3)) |-> nmi_ack);

    assert_holdoff_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(arm_live, 1) ||
         ($past(arm_live, 2) && !$past(rst, 1)) ||
         ($past(arm_live, 3) && !$past(rst, 2) && !$past(rst, 1)))
        |-> (!nmi_ack && !irq_ack));

    assert_exc_sets_mask_R8: assert property (@(posedge clk) disable iff (rst)
        exc_start |=> ccr_q[7]);

    assert_store_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_op == 3'd5 && !alu_valid && !exc_start) |=> $stable(ccr_q));

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_op == 3'd1 && !exc_start) |=> (ccr_q == $past(ctl_data)));

    assert_shift_clears_v_R6: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && alu_op[2:1] == 2'b11 && ctl_op == 3'd0) |=> !ccr_q[1]);

endmodule

bind ccr_flag_unit ccr_flag_unit_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .alu_valid (alu_valid),
    .alu_op    (alu_op),
    .ctl_op    (ctl_op),
    .ctl_data  (ctl_data),
    .exc_start (exc_start),
    .irq_req   (irq_req),
    .nmi_req   (nmi_req),
    .ccr_q     (ccr_q),
    .irq_ack   (irq_ack),
    .nmi_ack   (nmi_ack)
);

// File: tb/ccr_flag_unit_tb_top.sv
module ccr_flag_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alu_valid = 1'b0;
    logic [2:0]  alu_op = 3'd0;
    logic [1:0]  alu_size = 2'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] alu_result = '0;
    logic [2:0]  ctl_op = 3'd0;
    logic [7:0]  ctl_data = '0;
    logic        exc_start = 1'b0;
    logic        irq_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic [7:0]  ccr_q;
    logic        irq_ack;
    logic        nmi_ack;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    logic [7:0] exp_ccr;

    always #5 clk = ~clk;

    ccr_flag_unit dut_i (
        .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_op(alu_op),
        .alu_size(alu_size), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .alu_result(alu_result), .ctl_op(ctl_op), .ctl_data(ctl_data),
        .exc_start(exc_start), .irq_req(irq_req), .nmi_req(nmi_req),
        .ccr_q(ccr_q), .irq_ack(irq_ack), .nmi_ack(nmi_ack)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // returns {h,n,z,v,c}
    function automatic logic [4:0] model(input int op, input int sz, input logic [31:0] a,
                                         input logic [31:0] b, input logic c_old, input logic h_old,
                                         output logic [31:0] res);
        int w;
        logic [63:0] m, hm, ma, mb, r;
        longint sa, sb, sr, smax, smin;
        logic cin, c, h, v;
        w  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        m  = (64'd1 << w) - 1;
        hm = (64'd1 << (w - 4)) - 1;
        ma = {32'd0, a} & m;
        mb = {32'd0, b} & m;
        if (op == 5) begin mb = ma; ma = 0; end
        cin = ((op == 1) || (op == 3)) ? c_old : 1'b0;
        sa = ma[w-1] ? longint'(ma) - longint'(64'd1 << w) : longint'(ma);
        sb = mb[w-1] ? longint'(mb) - longint'(64'd1 << w) : longint'(mb);
        smax = longint'(64'd1 << (w - 1)) - 1;
        smin = -longint'(64'd1 << (w - 1));
        h = h_old; v = 1'b0; c = 1'b0; r = 0; sr = 0;
        if (op <= 1) begin
            r  = ma + mb + 64'(cin);
            c  = r[w];
            h  = (((ma & hm) + (mb & hm) + 64'(cin)) > hm);
            sr = sa + sb + longint'(cin);
            v  = (sr > smax) || (sr < smin);
        end else if (op <= 5) begin
            r  = ma - mb - 64'(cin);
            c  = (ma < mb + 64'(cin));
            h  = ((ma & hm) < (mb & hm) + 64'(cin));
            sr = sa - sb - longint'(cin);
            v  = (sr > smax) || (sr < smin);
        end else if (op == 6) begin
            r = ma << 1; c = ma[w-1];
        end else begin
            r = ma >> 1; c = ma[0];
        end
        r   = r & m;
        res = r[31:0];
        return {h, r[w-1], (r == 0), v, c};
    endfunction

    task automatic ctl_cycle(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        ctl_op = op; ctl_data = d;
        @(negedge clk);
        ctl_op = 3'd0;
    endtask

    logic [7:0] byte_set [16] = '{8'h00, 8'h01, 8'h07, 8'h08, 8'h0F, 8'h10, 8'h7F, 8'h80,
                                  8'h81, 8'hFE, 8'hFF, 8'h55, 8'hAA, 8'h3C, 8'hC3, 8'h78};

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state
        irq_req = 1'b1; nmi_req = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset value", 32'(ccr_q), 32'h80);
        check("R1 irq blocked by reset mask", 32'(irq_ack), 32'h0);
        check("R1 nmi open after reset", 32'(nmi_ack), 32'h1);
        irq_req = 1'b0; nmi_req = 1'b0;

        ctl_cycle(3'd1, 8'h00);
        exp_ccr = 8'h00;
        repeat (4) @(negedge clk);

        // R2-R6 flag sweep
        for (int sz = 0; sz < 3; sz++) begin
            for (int op = 0; op < 8; op++) begin
                for (int ia = 0; ia < 16; ia++) begin
                    for (int ib = 0; ib < 16; ib++) begin
                        logic [31:0] am, bm, rr, mk, junk;
                        logic [4:0]  f;
                        mk   = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
                        junk = 32'hA5C3_9E17 & ~mk;
                        am = {4{byte_set[ia]}} & mk;
                        bm = {byte_set[ib], byte_set[(ia + ib) % 16], byte_set[15 - ib], byte_set[ib]} & mk;
                        f = model(op, sz, am, bm, exp_ccr[0], exp_ccr[5], rr);
                        @(negedge clk);
                        alu_valid  = 1'b1;
                        alu_op     = 3'(op);
                        alu_size   = 2'(sz);
                        opnd_a     = am | junk;
                        opnd_b     = bm | junk;
                        alu_result = rr | junk;
                        @(negedge clk);
                        alu_valid = 1'b0;
                        exp_ccr[5] = f[4]; exp_ccr[3] = f[3]; exp_ccr[2] = f[2];
                        exp_ccr[1] = f[1]; exp_ccr[0] = f[0];
                        if (op >= 6) begin
                            check("R6 shift H kept", 32'(ccr_q[5]), 32'(f[4]));
                            check("R6 shift V clear", 32'(ccr_q[1]), 32'(f[1]));
                            check("R6 shift C out", 32'(ccr_q[0]), 32'(f[0]));
                        end else begin
                            check("R2 half carry", 32'(ccr_q[5]), 32'(f[4]));
                            check("R4 overflow", 32'(ccr_q[1]), 32'(f[1]));
                            check("R5 carry", 32'(ccr_q[0]), 32'(f[0]));
                        end
                        check("R3 negative", 32'(ccr_q[3]), 32'(f[3]));
                        check("R3 zero", 32'(ccr_q[2]), 32'(f[2]));
                        check("R7 upper bits kept", 32'({ccr_q[7:6], ccr_q[4]}), 32'({exp_ccr[7:6], exp_ccr[4]}));
                    end
                end
            end
        end

        // R7 control operations
        ctl_cycle(3'd1, 8'h5A); check("R7 load", 32'(ccr_q), 32'h5A);
        ctl_cycle(3'd2, 8'hF0); check("R7 and", 32'(ccr_q), 32'h50);
        ctl_cycle(3'd3, 8'h05); check("R7 or", 32'(ccr_q), 32'h55);
        ctl_cycle(3'd4, 8'hFF); check("R7 xor", 32'(ccr_q), 32'hAA);
        ctl_cycle(3'd5, 8'h00); check("R7 store no change", 32'(ccr_q), 32'hAA);
        @(negedge clk);
        ctl_op = 3'd1; ctl_data = 8'h3C;
        alu_valid = 1'b1; alu_op = 3'd0; alu_size = 2'd0;
        opnd_a = 32'h80; opnd_b = 32'h80; alu_result = 32'h00;
        @(negedge clk);
        ctl_op = 3'd0; alu_valid = 1'b0;
        check("R7 control wins over ALU", 32'(ccr_q), 32'h3C);

        // R10 hold-off after each writing control op, none after store
        ctl_cycle(3'd1, 8'h00);
        repeat (4) @(negedge clk);
        for (int k = 1; k <= 5; k++) begin
            logic [7:0] d;
            d = (k == 2) ? 8'h7F : 8'h00;
            irq_req = 1'b1; nmi_req = 1'b1;
            @(negedge clk);
            ctl_op = 3'(k); ctl_data = d;
            for (int t = 1; t <= 4; t++) begin
                @(negedge clk);
                ctl_op = 3'd0;
                if (k == 5 || t == 4) begin
                    check("R10 acks open", 32'({irq_ack, nmi_ack}), 32'h3);
                end else begin
                    check("R10 acks held off", 32'({irq_ack, nmi_ack}), 32'h0);
                end
            end
            irq_req = 1'b0; nmi_req = 1'b0;
        end

        // R9 mask behaviour
        ctl_cycle(3'd1, 8'h80);
        repeat (3) @(negedge clk);
        irq_req = 1'b1; nmi_req = 1'b1;
        #1;
        check("R9 irq masked by I", 32'(irq_ack), 32'h0);
        check("R9 nmi ignores I", 32'(nmi_ack), 32'h1);
        irq_req = 1'b0; nmi_req = 1'b0;
        ctl_cycle(3'd1, 8'h40);
        repeat (3) @(negedge clk);
        irq_req = 1'b1;
        #1;
        check("R9 irq accepted with I clear", 32'(irq_ack), 32'h1);
        irq_req = 1'b0;
        #1;
        check("R9 no ack without request", 32'({irq_ack, nmi_ack}), 32'h0);

        // R8 exception start
        @(negedge clk);
        exc_start = 1'b1;
        @(negedge clk);
        exc_start = 1'b0;
        check("R8 exception sets I", 32'(ccr_q), 32'hC0);
        @(negedge clk);
        exc_start = 1'b1; ctl_op = 3'd1; ctl_data = 8'h11;
        @(negedge clk);
        exc_start = 1'b0; ctl_op = 3'd0;
        check("R8 exception after load", 32'(ccr_q), 32'h91);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset again", 32'(ccr_q), 32'h80);

        finish_run();
    end

endmodule